// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the control core of a small accumulator machine. It runs each instruction through a fixed series of subcycles. A fetch subcycle reads the instruction word. An optional indirect subcycle turns an address field into an operand address. An execute subcycle performs the operation. An interrupt entry subcycle, when needed, saves the return address and redirects control to a handler. Every step is a transfer between the program counter, an address holding register, a data holding register and an instruction register. The block drives a single-port memory that can stall any access by holding its ready input low.

An external memory model or a real RAM with a ready handshake connects to the memory pins. A request line raises an interrupt. The current subcycle is visible on a state output, so the order of subcycles for each instruction can be observed from outside.

Top module: `icyc_seq`

## Requirements
- R1: While reset is held, the state output reads 0 (fetch), the program counter reads RESET_PC, the accumulator reads 0, the interrupt enable reads 0, and neither mem_rd nor mem_wr is asserted.
- R2: Fetch reads the word at the current program counter. The program counter increases by one when that read completes, so an instruction that does not jump leaves it one above its own address.
- R3: An instruction word has its opcode in bits [15:13], an indirect flag in bit 12 and an address in bits [11:0]. With the flag set, the state output shows 1 (indirect) between fetch and execute, and one extra read at the address field supplies the effective address from the low 12 bits of the returned word. With the flag clear, state 1 never appears.
- R4: Opcode 000 loads the accumulator from the effective address. Opcode 010 adds the word there to the accumulator, modulo 2^16. Opcode 001 writes the accumulator there. Opcode 011 sets the program counter to the effective address without a data access. Opcode 100 sets the interrupt enable. Opcodes 101 to 111 change nothing beyond the program counter step.
- R5: A read or write request holds its address, its write data and its request line until a cycle with mem_ready high. Exactly one access completes in each such cycle.
- R6: If irq is high and the enable was already set when an execute subcycle began, that subcycle is followed by state 3 (interrupt). Interrupt entry writes the address of the next instruction to SAVE_ADDR, loads HANDLER_ADDR into the program counter and clears the enable. The next fetch reads the handler's first word.
- R7: While the enable is clear, a high irq has no effect: state 3 does not occur and the program runs on in sequence.
- R8: The state output encodes fetch=0, indirect=1, execute=2, interrupt=3. Its only transitions are fetch to indirect or execute, indirect to execute, execute to fetch or interrupt, and interrupt to fetch.
- R9: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid while mem_ready is high |
| mem_ready | input | 1 | Access completes this cycle |
| irq | input | 1 | Interrupt request, level sensitive |
| state | output | 2 | Current subcycle |
| pc | output | ADDR_W | Program counter |
| acc | output | DATA_W | Accumulator |
| int_en | output | 1 | Interrupt enable |

## Verification
A program runs twice: once with zero-wait memory and once with three wait states. The run mixes direct and indirect forms of load, add, store and jump. Comparing the two runs separates correct ready handling from logic that only works when memory answers at once. Counting completed accesses per instruction, and noting whether state 1 or 3 appeared, distinguishes the direct form from the indirect form, and a jump from a data access. Holding irq high from the start separates a disabled request, which has no effect, from an enabled one, which is taken only after the next full instruction. An add that overflows and an unused opcode cover the remaining corners. A separate long-stall run checks that the fetch address holds and that the program counter waits for the read to complete.

// File: rtl/icyc_pkg.sv
`timescale 1ns/1ps
package icyc_pkg;
    typedef enum logic [1:0] {
        SC_FETCH = 2'd0,
        SC_IND   = 2'd1,
        SC_EXEC  = 2'd2,
        SC_INTR  = 2'd3
    } subcyc_e;

    localparam int OP_W = 3;
    localparam logic [OP_W-1:0] OP_LOAD  = 3'd0;
    localparam logic [OP_W-1:0] OP_STORE = 3'd1;
    localparam logic [OP_W-1:0] OP_ADD   = 3'd2;
    localparam logic [OP_W-1:0] OP_JUMP  = 3'd3;
    localparam logic [OP_W-1:0] OP_INTEN = 3'd4;
endpackage

// File: rtl/icyc_decode.sv
`timescale 1ns/1ps
module icyc_decode
    import icyc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic [DATA_W-1:0] instr,
    output logic [OP_W-1:0]   opcode,
    output logic              indirect,
    output logic [ADDR_W-1:0] field,
    output logic              rd_op,
    output logic              wr_op
);
    localparam int IND_BIT = DATA_W - OP_W - 1;

    assign opcode   = instr[DATA_W-1 -: OP_W];
    assign indirect = instr[IND_BIT];
    assign field    = instr[ADDR_W-1:0];
    assign rd_op    = (opcode == OP_LOAD) || (opcode == OP_ADD);
    assign wr_op    = (opcode == OP_STORE);
endmodule

// File: rtl/icyc_alu.sv
`timescale 1ns/1ps
module icyc_alu
    import icyc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [OP_W-1:0]   opcode,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result
);
    always_comb begin
        unique case (opcode)
            OP_LOAD: result = operand;
            OP_ADD:  result = acc_in + operand;
            default: result = acc_in;
        endcase
    end
endmodule

// File: rtl/icyc_seq.sv
`timescale 1ns/1ps
module icyc_seq
    import icyc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] RESET_PC     = 12'h010,
    parameter logic [ADDR_W-1:0] SAVE_ADDR    = 12'h0FF,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h080
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    input  logic              irq,
    output logic [1:0]        state,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] acc,
    output logic              int_en
);
    localparam int STEP_W = 2;
    localparam int PAD_W  = DATA_W - ADDR_W;

    typedef struct packed {
        subcyc_e           sc;
        logic [STEP_W-1:0] step;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] mbr;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] acc;
        logic              ien;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [OP_W-1:0]   op;
    logic              ind;
    logic [ADDR_W-1:0] ir_field;
    logic              rd_op;
    logic              wr_op;
    logic [DATA_W-1:0] alu_res;
    logic              exec_done;

    icyc_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
        .instr    (seq_q.ir),
        .opcode   (op),
        .indirect (ind),
        .field    (ir_field),
        .rd_op    (rd_op),
        .wr_op    (wr_op)
    );

    icyc_alu #(.DATA_W(DATA_W)) u_alu (
        .opcode  (op),
        .acc_in  (seq_q.acc),
        .operand (mem_rdata),
        .result  (alu_res)
    );

    always_comb begin
        seq_d     = seq_q;
        exec_done = 1'b0;
        unique case (seq_q.sc)
            SC_FETCH: begin
                unique case (seq_q.step)
                    2'd0: begin
                        seq_d.mar  = seq_q.pc;
                        seq_d.step = 2'd1;
                    end
                    2'd1: begin
                        if (mem_ready) begin
                            seq_d.mbr  = mem_rdata;
                            seq_d.pc   = seq_q.pc + 1'b1;
                            seq_d.step = 2'd2;
                        end
                    end
                    2'd2: begin
                        seq_d.ir   = seq_q.mbr;
                        seq_d.step = 2'd3;
                    end
                    default: begin
                        seq_d.step = 2'd0;
                        seq_d.sc   = ind ? SC_IND : SC_EXEC;
                    end
                endcase
            end
            SC_IND: begin
                unique case (seq_q.step)
                    2'd0: begin
                        seq_d.mar  = ir_field;
                        seq_d.step = 2'd1;
                    end
                    2'd1: begin
                        if (mem_ready) begin
                            seq_d.mbr  = mem_rdata;
                            seq_d.step = 2'd0;
                            seq_d.sc   = SC_EXEC;
                        end
                    end
                    default: seq_d.step = 2'd0;
                endcase
            end
            SC_EXEC: begin
                unique case (seq_q.step)
                    2'd0: begin
                        seq_d.mar = seq_q.mbr[ADDR_W-1:0];
                        if (rd_op || wr_op) begin
                            seq_d.step = 2'd1;
                        end else begin
                            if (op == OP_JUMP)  seq_d.pc  = seq_q.mbr[ADDR_W-1:0];
                            if (op == OP_INTEN) seq_d.ien = 1'b1;
                            exec_done = 1'b1;
                        end
                    end
                    2'd1: begin
                        if (mem_ready) begin
                            if (rd_op) seq_d.acc = alu_res;
                            exec_done = 1'b1;
                        end
                    end
                    default: seq_d.step = 2'd0;
                endcase
            end
            default: begin
                unique case (seq_q.step)
                    2'd0: begin
                        seq_d.mbr  = {{PAD_W{1'b0}}, seq_q.pc};
                        seq_d.mar  = SAVE_ADDR;
                        seq_d.step = 2'd1;
                    end
                    2'd1: begin
                        if (mem_ready) begin
                            seq_d.pc   = HANDLER_ADDR;
                            seq_d.ien  = 1'b0;
                            seq_d.step = 2'd0;
                            seq_d.sc   = SC_FETCH;
                        end
                    end
                    default: seq_d.step = 2'd0;
                endcase
            end
        endcase
        if (exec_done) begin
            seq_d.step = 2'd0;
            seq_d.sc   = (irq && seq_q.ien) ? SC_INTR : SC_FETCH;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{sc: SC_FETCH, step: '0, pc: RESET_PC, mar: '0,
                       mbr: '0, ir: '0, acc: '0, ien: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mem_addr  = seq_q.mar;
    assign mem_rd    = (seq_q.step == 2'd1) &&
                       ((seq_q.sc == SC_FETCH) || (seq_q.sc == SC_IND) ||
                        ((seq_q.sc == SC_EXEC) && rd_op));
    assign mem_wr    = (seq_q.step == 2'd1) &&
                       (((seq_q.sc == SC_EXEC) && wr_op) || (seq_q.sc == SC_INTR));
    assign mem_wdata = (seq_q.sc == SC_INTR) ? seq_q.mbr : seq_q.acc;
    assign state     = seq_q.sc;
    assign pc        = seq_q.pc;
    assign acc       = seq_q.acc;
    assign int_en    = seq_q.ien;
endmodule

// File: rtl/icyc_seq_chk.sv
`timescale 1ns/1ps
module icyc_seq_chk
    import icyc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h080
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic [1:0]        state,
    input logic [ADDR_W-1:0] pc,
    input logic              int_en
);
    // R1: reset leaves no request and the enable clear
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!mem_rd && !mem_wr && !int_en));

    // R5: a pending read keeps its request and address
    p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

    // R5: a pending write keeps request, address and data
    p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    // R9: never read and write together
    p_rd_wr_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R8: legal subcycle transitions
    p_from_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SC_FETCH) |=> (state != SC_INTR));
    p_from_ind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SC_IND) |=> (state == SC_IND || state == SC_EXEC));
    p_from_exec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SC_EXEC) |=> (state != SC_IND));
    p_from_intr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SC_INTR) |=> (state == SC_INTR || state == SC_FETCH));

    // R6: leaving interrupt entry lands on the handler with enable clear
    p_intr_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == SC_INTR && state == SC_FETCH) |-> (!int_en && pc == HANDLER_ADDR));

    // R7: interrupt entry only follows execute with the enable set
    p_intr_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == SC_EXEC && state == SC_INTR) |-> $past(int_en));
endmodule

bind icyc_seq icyc_seq_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .HANDLER_ADDR(HANDLER_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .state     (state),
    .pc        (pc),
    .int_en    (int_en)
);

// File: tb/icyc_seq_tb.sv
`timescale 1ns/1ps
module icyc_seq_tb;
    localparam int DW = 16;
    localparam int AW = 12;
    localparam int NV = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          mem_ready;
    logic          irq = 1'b0;
    logic [1:0]    state;
    logic [AW-1:0] pc;
    logic [DW-1:0] acc;
    logic          int_en;

    always #10 clk = ~clk;

    icyc_seq u_dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .irq(irq), .state(state), .pc(pc),
        .acc(acc), .int_en(int_en)
    );

    // memory model with programmable wait states
    logic [DW-1:0] mem [0:255];
    int lat = 0;
    int wcnt = 0;
    assign mem_ready = (mem_rd || mem_wr) && (wcnt >= lat);
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) begin
        if ((mem_rd || mem_wr) && !mem_ready) wcnt <= wcnt + 1;
        else wcnt <= 0;
        if (mem_wr && mem_ready) mem[mem_addr[7:0]] <= mem_wdata;
    end

    int checks = 0;
    int fails = 0;
    int nacc = 0;
    int order_err = 0;
    int both_err = 0;
    logic saw_ind = 1'b0;
    logic saw_int = 1'b0;
    logic [1:0] prev_st = 2'd0;

    always @(negedge clk) begin
        if (rst_n) begin
            if ((mem_rd || mem_wr) && mem_ready) nacc++;
            if (state == 2'd1) saw_ind = 1'b1;
            if (state == 2'd3) saw_int = 1'b1;
            if (mem_rd && mem_wr) both_err++;
            if (!((prev_st == state) ||
                  (prev_st == 2'd0 && (state == 2'd1 || state == 2'd2)) ||
                  (prev_st == 2'd1 && state == 2'd2) ||
                  (prev_st == 2'd2 && (state == 2'd0 || state == 2'd3)) ||
                  (prev_st == 2'd3 && state == 2'd0)))
                order_err++;
        end
        prev_st = state;
    end

    typedef struct packed {
        logic        ind;
        logic        intr;
        logic        ien;
        logic [1:0]  nacc;
        logic [15:0] acc;
        logic [11:0] pc;
    } vec_t;

    // one entry per instruction of the program, in execution order
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b0, 1'b0, 1'b0, 2'd2, 16'h0005, 12'h011},  // LDA 40
        '{1'b1, 1'b0, 1'b0, 2'd3, 16'h0008, 12'h012},  // ADD @42
        '{1'b0, 1'b0, 1'b0, 2'd2, 16'h0008, 12'h013},  // STA 43
        '{1'b1, 1'b0, 1'b0, 2'd3, 16'h0008, 12'h014},  // STA @44
        '{1'b1, 1'b0, 1'b0, 2'd2, 16'h0008, 12'h020},  // JMP @45
        '{1'b0, 1'b0, 1'b0, 2'd2, 16'h0010, 12'h021},  // ADD 43
        '{1'b0, 1'b0, 1'b0, 2'd1, 16'h0010, 12'h030},  // JMP 30
        '{1'b0, 1'b0, 1'b0, 2'd2, 16'h0008, 12'h031},  // LDA 50
        '{1'b0, 1'b0, 1'b1, 2'd1, 16'h0008, 12'h032},  // enable
        '{1'b0, 1'b1, 1'b0, 2'd3, 16'h0003, 12'h080},  // LDA 41 then entry
        '{1'b0, 1'b0, 1'b0, 2'd2, 16'h0005, 12'h081},  // handler LDA 40
        '{1'b0, 1'b0, 1'b0, 2'd2, 16'h0004, 12'h082},  // ADD 46 wraps
        '{1'b0, 1'b0, 1'b0, 2'd1, 16'h0004, 12'h083}   // unused opcode
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic load_mem();
        for (int a = 0; a < 256; a++) mem[a] = 16'h0000;
        mem[8'h10] = 16'h0040; mem[8'h11] = 16'h5042; mem[8'h12] = 16'h2043;
        mem[8'h13] = 16'h3044; mem[8'h14] = 16'h7045; mem[8'h20] = 16'h4043;
        mem[8'h21] = 16'h6030; mem[8'h30] = 16'h0050; mem[8'h31] = 16'h8000;
        mem[8'h32] = 16'h0041; mem[8'h80] = 16'h0040; mem[8'h81] = 16'h4046;
        mem[8'h82] = 16'hA000;
        mem[8'h40] = 16'h0005; mem[8'h41] = 16'h0003; mem[8'h42] = 16'h0041;
        mem[8'h44] = 16'h0050; mem[8'h45] = 16'h0020; mem[8'h46] = 16'hFFFF;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        load_mem();
        repeat (3) @(negedge clk);
        check("R1 state", 32'(state), 32'h0);
        check("R1 pc", 32'(pc), 32'h010);
        check("R1 acc", 32'(acc), 32'h0);
        check("R1 int_en", 32'(int_en), 32'h0);
        check("R1 no request", 32'({mem_rd, mem_wr}), 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic run_vec(int i);
        nacc = 0;
        saw_ind = 1'b0;
        saw_int = 1'b0;
        do @(negedge clk); while (state == 2'd0);
        do @(negedge clk); while (state != 2'd0);
        check($sformatf("R2 R4 pc vec %0d", i), 32'(pc), 32'(VEC[i].pc));
        check($sformatf("R4 acc vec %0d", i), 32'(acc), 32'(VEC[i].acc));
        check($sformatf("R3 indirect seen vec %0d", i), 32'(saw_ind), 32'(VEC[i].ind));
        check($sformatf("R6 R7 interrupt seen vec %0d", i), 32'(saw_int), 32'(VEC[i].intr));
        check($sformatf("R6 enable vec %0d", i), 32'(int_en), 32'(VEC[i].ien));
        check($sformatf("R5 access count vec %0d", i), 32'(nacc), 32'(VEC[i].nacc));
    endtask

    initial begin
        for (int p = 0; p < 2; p++) begin
            lat = (p == 0) ? 0 : 3;
            irq = 1'b1;
            do_reset();
            for (int i = 0; i < NV; i++) run_vec(i);
            check("R4 store direct", 32'(mem[8'h43]), 32'h0008);
            check("R4 store indirect", 32'(mem[8'h50]), 32'h0008);
            check("R6 saved return address", 32'(mem[8'hFF]), 32'h0033);
        end

        // long stall on the first fetch
        irq = 1'b0;
        lat = 4;
        do_reset();
        do @(negedge clk); while (!mem_rd);
        for (int k = 0; k < 4; k++) begin
            check("R5 fetch held", 32'({mem_rd, mem_ready}), 32'h2);
            check("R2 fetch address", 32'(mem_addr), 32'h010);
            check("R2 pc waits for read", 32'(pc), 32'h010);
            @(negedge clk);
        end
        check("R5 ready after wait states", 32'(mem_ready), 32'h1);
        @(negedge clk);
        check("R2 pc step after read", 32'(pc), 32'h011);

        check("R8 subcycle order", 32'(order_err), 32'h0);
        check("R9 exclusive requests", 32'(both_err), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule